// File: doc/BRIEF.md
# Two-Wire Front-End Control Slave Register File

This block is the slave side of a two-wire clock/data control bus of the RF front-end kind, which is used to program a buck-boost supply. The bus master opens each frame with a start pattern: the data line pulses high and then low while the clock stays low. The frame then carries a 4-bit slave address, an 8-bit command word with an odd-parity bit, and for some commands a data word with its own odd-parity bit. Every bit is launched on a rising bus-clock edge and sampled on the falling edge. The slave accepts three kinds of frame. A compact write puts a 7-bit voltage code into register 00h. A full register write carries a 5-bit register address. A register read returns 8 data bits and a parity bit.

The block runs on a fast system clock. It sees the bus clock and the data line as plain synchronous inputs and finds their edges itself. The shared data line is split into an input, an output and an output enable. The supply/reset line, called `vio_i` here, gates the whole block. While it is low, every register returns to its default and the data line is released. The register fields are driven out as ports to the converter control logic.

Top module: `rffe_slave`

## Requirements
- R1: While `vio_i` is low, the fields hold their defaults, and the defaults remain when `vio_i` rises. The defaults are: voltage code 0, mode select 01b, both general outputs low, power mode 01b, trigger bits 0.
- R2: Writes are accepted when the frame address is the unique address 0101b, the group address 0000b or the broadcast address 0000b. A write sent to any other address changes nothing.
- R3: A command word with bit 7 set is a compact write. Its bits 6:0 replace the voltage code and no other field changes.
- R4: A command word 010aaaaa is a register write to address aaaaa. Register 00h bits 6:0 hold the voltage code. Register 01h bits 7:6 hold the mode select. Register 02h bit 7 drives general output 0 and bit 6 drives general output 1. Register 1Ch bits 7:6 hold the power mode and bits 5:0 hold the trigger bits.
- R5: Address and command together carry one odd-parity bit, and the data word carries another. A parity error in either one discards the write.
- R6: A command word 011aaaaa sent to the unique address is a read. After one bus-park cycle the slave returns the 8 data bits, MSB first, followed by an odd-parity bit. Register 1Dh reads A0h and register 1Eh reads C4h. Register 1Fh reads 15h: bits 7:6 are zero, bits 5:4 are the manufacturer bits and bits 3:0 are the unique address. Reserved bits read 0.
- R7: Addresses 03h to 1Bh read as zero. Writes to those addresses and to 1Dh, 1Eh and 1Fh change nothing.
- R8: A read sent to the broadcast address gets no response, and the output enable stays low.
- R9: The output enable is high only during the 9 response bits. It drops on the rising edge that opens the final park cycle and is low whenever no frame is in progress.
- R10: Pulling `vio_i` low in the middle of a frame drops the output enable and restores every default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| vio_i | input | 1 | Interface supply; low holds the block in reset |
| sclk_i | input | 1 | Bus clock |
| sdi_i | input | 1 | Bus data, incoming |
| sdo_o | output | 1 | Bus data, outgoing |
| sdo_oe_o | output | 1 | Drive enable for `sdo_o` |
| vset_o | output | 7 | Output voltage code |
| mode_sel_o | output | 2 | PWM/PFM mode select |
| gpo0_o | output | 1 | General output 0 |
| gpo1_o | output | 1 | General output 1 |
| pwr_mode_o | output | 2 | Power mode field |
| trig_o | output | 6 | Trigger bits |

## Verification
A register field changes two system clocks after the slave samples the falling bus-clock edge that completes the write. The response bit and its enable change one system clock after a rising bus-clock edge is seen. The bench holds each bus-clock level for four system clocks, so it can sample read responses at the end of each high phase. Register fields are compared on every system clock against a behavioural model, but only between frames, once every pending update has landed.

// File: rtl/rffe_slave_pkg.sv
package rffe_slave_pkg;

    localparam int ADDR_W    = 4;
    localparam int CMD_W     = 8;
    localparam int DATA_W    = 8;
    localparam int REG_AW    = 5;
    localparam int HDR_BITS  = ADDR_W + CMD_W + 1;   // address, command, parity
    localparam int WORD_BITS = DATA_W + 1;           // data, parity
    localparam int CNT_W     = 5;

    // falling-edge counts (value before increment) at which events occur
    localparam int LAST_HDR   = HDR_BITS - 1;                 // 12
    localparam int LAST_WDATA = HDR_BITS + WORD_BITS - 1;     // 21
    localparam int RD_LOAD    = HDR_BITS;                     // 13, park fall
    localparam int RD_FIRST   = HDR_BITS + 1;                 // 14
    localparam int RD_LAST    = HDR_BITS + WORD_BITS;         // 22
    localparam int RD_PARK    = RD_LAST + 1;                  // 23

    localparam logic [ADDR_W-1:0] BCAST_ID = '0;

    localparam logic [REG_AW-1:0] RA_VSET = 5'h00;
    localparam logic [REG_AW-1:0] RA_MODE = 5'h01;
    localparam logic [REG_AW-1:0] RA_GPO  = 5'h02;
    localparam logic [REG_AW-1:0] RA_PM   = 5'h1C;
    localparam logic [REG_AW-1:0] RA_PROD = 5'h1D;
    localparam logic [REG_AW-1:0] RA_MFR  = 5'h1E;
    localparam logic [REG_AW-1:0] RA_ID   = 5'h1F;

    typedef enum logic [2:0] {FR_IDLE, FR_HEAD, FR_WDATA, FR_RDATA, FR_PARK} frame_st_e;
    typedef enum logic [1:0] {CK_REG0, CK_WRITE, CK_READ, CK_OTHER} cmd_kind_e;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic [6:0] vset;
        logic [1:0] mode;
        logic       gpo0;
        logic       gpo1;
        logic [1:0] pmode;
        logic [5:0] trig;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_DEFAULT = '{vset: 7'd0, mode: 2'b01, gpo0: 1'b0,
                                            gpo1: 1'b0, pmode: 2'b01, trig: 6'd0};

    function automatic cmd_kind_e classify(input logic [2:0] top3);
        if (top3[2])              return CK_REG0;
        else if (top3 == 3'b010)  return CK_WRITE;
        else if (top3 == 3'b011)  return CK_READ;
        else                      return CK_OTHER;
    endfunction

    function automatic logic odd_bit(input logic [DATA_W-1:0] v);
        return ~^v;
    endfunction

    function automatic logic is_writable(input logic [REG_AW-1:0] a);
        return (a == RA_VSET) || (a == RA_MODE) || (a == RA_GPO) || (a == RA_PM);
    endfunction

endpackage

// File: rtl/rffe_frame_rx.sv
module rffe_frame_rx
    import rffe_slave_pkg::*;
#(
    parameter logic [ADDR_W-1:0] USID = 4'h5,
    parameter logic [ADDR_W-1:0] GSID = 4'h0
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                sclk_i,
    input  logic                sdi_i,
    input  logic [DATA_W-1:0]   rd_data_i,
    output logic                wr_en_o,
    output reg_wr_t             wr_o,
    output logic [REG_AW-1:0]   rd_addr_o,
    output logic                sdo_o,
    output logic                sdo_oe_o
);

    frame_st_e               st;
    logic [CNT_W-1:0]        cnt;
    logic [HDR_BITS-2:0]     sh;
    logic                    sclk_q, sdi_q;
    logic [REG_AW-1:0]       waddr_q;
    logic                    hdr_ok_q;
    logic [WORD_BITS-1:0]    rd_word;

    logic                    rise_ev, fall_ev, start_ev;
    logic [HDR_BITS-1:0]     hdr_full;
    logic [ADDR_W-1:0]       f_addr;
    logic [CMD_W-1:0]        f_cmd;
    logic                    hdr_par_ok, hit_wr, hit_rd;
    logic [WORD_BITS-1:0]    word_full;
    logic                    word_ok;
    logic [3:0]              rd_idx;

    assign rise_ev  = sclk_i & ~sclk_q;
    assign fall_ev  = ~sclk_i & sclk_q;
    assign start_ev = ~sclk_i & ~sclk_q & sdi_q & ~sdi_i;

    assign hdr_full   = {sh, sdi_i};
    assign f_addr     = hdr_full[HDR_BITS-1 -: ADDR_W];
    assign f_cmd      = hdr_full[CMD_W:1];
    assign hdr_par_ok = ^hdr_full;
    assign hit_wr     = (f_addr == USID) || (f_addr == GSID) || (f_addr == BCAST_ID);
    assign hit_rd     = (f_addr == USID);

    assign word_full  = {sh[DATA_W-1:0], sdi_i};
    assign word_ok    = ^word_full;
    assign rd_idx     = 4'(CNT_W'(RD_LAST) - cnt);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st        <= FR_IDLE;
            cnt       <= '0;
            sh        <= '0;
            sclk_q    <= 1'b0;
            sdi_q     <= 1'b0;
            waddr_q   <= '0;
            hdr_ok_q  <= 1'b0;
            rd_word   <= '0;
            rd_addr_o <= '0;
            wr_en_o   <= 1'b0;
            wr_o      <= '0;
            sdo_o     <= 1'b0;
            sdo_oe_o  <= 1'b0;
        end else begin
            sclk_q  <= sclk_i;
            sdi_q   <= sdi_i;
            wr_en_o <= 1'b0;
            if (st != FR_RDATA) begin
                sdo_o    <= 1'b0;
                sdo_oe_o <= 1'b0;
            end
            unique case (st)
                FR_IDLE: begin
                    if (start_ev) begin
                        st  <= FR_HEAD;
                        cnt <= '0;
                    end
                end
                FR_HEAD: begin
                    if (fall_ev) begin
                        sh  <= {sh[HDR_BITS-3:0], sdi_i};
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(LAST_HDR)) begin
                            unique case (classify(f_cmd[7:5]))
                                CK_REG0: begin
                                    if (hdr_par_ok && hit_wr) begin
                                        wr_en_o <= 1'b1;
                                        wr_o    <= '{addr: RA_VSET, data: {1'b0, f_cmd[6:0]}};
                                    end
                                    st <= FR_PARK;
                                end
                                CK_WRITE: begin
                                    waddr_q  <= f_cmd[REG_AW-1:0];
                                    hdr_ok_q <= hdr_par_ok && hit_wr;
                                    st       <= FR_WDATA;
                                end
                                CK_READ: begin
                                    if (hdr_par_ok && hit_rd) begin
                                        rd_addr_o <= f_cmd[REG_AW-1:0];
                                        st        <= FR_RDATA;
                                    end else begin
                                        st <= FR_IDLE;
                                    end
                                end
                                default: st <= FR_IDLE;
                            endcase
                        end
                    end
                end
                FR_WDATA: begin
                    if (fall_ev) begin
                        sh  <= {sh[HDR_BITS-3:0], sdi_i};
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(LAST_WDATA)) begin
                            if (hdr_ok_q && word_ok) begin
                                wr_en_o <= 1'b1;
                                wr_o    <= '{addr: waddr_q, data: word_full[WORD_BITS-1:1]};
                            end
                            st <= FR_PARK;
                        end
                    end
                end
                FR_RDATA: begin
                    if (fall_ev) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(RD_LOAD))
                            rd_word <= {rd_data_i, odd_bit(rd_data_i)};
                        if (cnt == CNT_W'(RD_PARK))
                            st <= FR_IDLE;
                    end else if (rise_ev) begin
                        if (cnt >= CNT_W'(RD_FIRST) && cnt <= CNT_W'(RD_LAST)) begin
                            sdo_oe_o <= 1'b1;
                            sdo_o    <= rd_word[rd_idx];
                        end else begin
                            sdo_oe_o <= 1'b0;
                            sdo_o    <= 1'b0;
                        end
                    end
                end
                FR_PARK: begin
                    if (fall_ev) st <= FR_IDLE;
                end
                default: st <= FR_IDLE;
            endcase
        end
    end

    // R9: the line is driven only inside a read frame
    a_r9_oe_inside_read: assert property (@(posedge clk_i) disable iff (rst_i)
        sdo_oe_o |-> (st == FR_RDATA));

    // R9: drive starts only after a rising bus-clock edge
    a_r9_oe_starts_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sdo_oe_o) |-> $past(rise_ev));

    // R5: a write strobe always follows a sampled falling edge
    a_r5_write_after_sample: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_o |-> $past(fall_ev));

endmodule

// File: rtl/rffe_regs.sv
module rffe_regs
    import rffe_slave_pkg::*;
#(
    parameter logic [ADDR_W-1:0] USID       = 4'h5,
    parameter logic [DATA_W-1:0] PRODUCT_ID = 8'hA0,
    parameter logic [9:0]        MFR_ID     = 10'h1C4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  reg_wr_t           wr_i,
    input  logic [REG_AW-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output ctrl_regs_t        q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= CTRL_DEFAULT;
        end else if (wr_en_i) begin
            unique case (wr_i.addr)
                RA_VSET: q_o.vset <= wr_i.data[6:0];
                RA_MODE: q_o.mode <= wr_i.data[7:6];
                RA_GPO: begin
                    q_o.gpo0 <= wr_i.data[7];
                    q_o.gpo1 <= wr_i.data[6];
                end
                RA_PM: begin
                    q_o.pmode <= wr_i.data[7:6];
                    q_o.trig  <= wr_i.data[5:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr_i)
            RA_VSET: rd_data_o = {1'b0, q_o.vset};
            RA_MODE: rd_data_o = {q_o.mode, 6'd0};
            RA_GPO:  rd_data_o = {q_o.gpo0, q_o.gpo1, 6'd0};
            RA_PM:   rd_data_o = {q_o.pmode, q_o.trig};
            RA_PROD: rd_data_o = PRODUCT_ID;
            RA_MFR:  rd_data_o = MFR_ID[7:0];
            RA_ID:   rd_data_o = {2'b00, MFR_ID[9:8], USID};
            default: rd_data_o = '0;
        endcase
    end

    // R1: leaving reset always shows the defaults
    a_r1_defaults_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (q_o == CTRL_DEFAULT));

    // R7: writes to read-only or reserved addresses leave every field alone
    a_r7_ro_write_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !is_writable(wr_i.addr)) |=> $stable(q_o));

    // R3: a write to register zero touches only the voltage code
    a_r3_vset_only: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_i.addr == RA_VSET) |=>
            ($stable(q_o.mode) && $stable(q_o.gpo0) && $stable(q_o.gpo1)
             && $stable(q_o.pmode) && $stable(q_o.trig)));

endmodule

// File: rtl/rffe_slave.sv
module rffe_slave
    import rffe_slave_pkg::*;
#(
    parameter logic [3:0] USID       = 4'h5,
    parameter logic [3:0] GSID       = 4'h0,
    parameter logic [7:0] PRODUCT_ID = 8'hA0,
    parameter logic [9:0] MFR_ID     = 10'h1C4
) (
    input  logic       clk_i,
    input  logic       vio_i,
    input  logic       sclk_i,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       sdo_oe_o,
    output logic [6:0] vset_o,
    output logic [1:0] mode_sel_o,
    output logic       gpo0_o,
    output logic       gpo1_o,
    output logic [1:0] pwr_mode_o,
    output logic [5:0] trig_o
);

    logic              rst;
    logic              wr_en;
    reg_wr_t           wr;
    logic [REG_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    ctrl_regs_t        regs;

    assign rst = ~vio_i;

    rffe_frame_rx #(.USID(USID), .GSID(GSID)) u_rx (
        .clk_i     (clk_i),
        .rst_i     (rst),
        .sclk_i    (sclk_i),
        .sdi_i     (sdi_i),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .wr_o      (wr),
        .rd_addr_o (rd_addr),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o)
    );

    rffe_regs #(.USID(USID), .PRODUCT_ID(PRODUCT_ID), .MFR_ID(MFR_ID)) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_i      (wr),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .q_o       (regs)
    );

    assign vset_o     = regs.vset;
    assign mode_sel_o = regs.mode;
    assign gpo0_o     = regs.gpo0;
    assign gpo1_o     = regs.gpo1;
    assign pwr_mode_o = regs.pmode;
    assign trig_o     = regs.trig;

endmodule

// File: tb/rffe_slave_test.sv
`timescale 1ns/1ps
module rffe_slave_test;

    logic clk = 1'b0;
    logic vio = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, g0, g1;
    logic [6:0] vset;
    logic [1:0] msel, pmode;
    logic [5:0] trig;

    always #4 clk = ~clk;   // 125 MHz

    rffe_slave uut (
        .clk_i(clk), .vio_i(vio), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .vset_o(vset), .mode_sel_o(msel),
        .gpo0_o(g0), .gpo1_o(g1), .pwr_mode_o(pmode), .trig_o(trig)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  busy   = 1'b1;
    bit  done   = 1'b0;

    // behavioural model of the register fields
    logic [6:0] m_vset;
    logic [1:0] m_mode, m_pm;
    logic       m_g0, m_g1;
    logic [5:0] m_trig;

    task automatic m_reset();
        m_vset = 7'd0; m_mode = 2'b01; m_g0 = 1'b0; m_g1 = 1'b0;
        m_pm = 2'b01; m_trig = 6'd0;
    endtask

    task automatic m_write(input logic [4:0] a, input logic [7:0] d);
        case (a)
            5'h00: m_vset = d[6:0];
            5'h01: m_mode = d[7:6];
            5'h02: begin m_g0 = d[7]; m_g1 = d[6]; end
            5'h1C: begin m_pm = d[7:6]; m_trig = d[5:0]; end
            default: ;
        endcase
    endtask

    function automatic logic [7:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return {1'b0, m_vset};
            5'h01: return {m_mode, 6'd0};
            5'h02: return {m_g0, m_g1, 6'd0};
            5'h1C: return {m_pm, m_trig};
            5'h1D: return 8'hA0;
            5'h1E: return 8'hC4;
            5'h1F: return 8'h15;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit hits(input logic [3:0] a);
        return (a == 4'h5) || (a == 4'h0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // settled comparison on every clock between frames (R1..R5, R7, R9)
    always @(negedge clk) begin
        if (!busy && !done && vio)
            chk("R4 fields/R9 idle enable",
                {8'd0, vset, msel, g0, g1, pmode, trig, sdo_oe},
                {8'd0, m_vset, m_mode, m_g0, m_g1, m_pm, m_trig, 1'b0});
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_frame();
        sclk = 1'b0; sdi = 1'b1; tick(4);
        sdi = 1'b0; tick(4);
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b1; sdi = b; tick(4);
        sclk = 1'b0; tick(4);
    endtask

    task automatic header(input logic [3:0] a, input logic [7:0] cmd, input bit bad);
        logic p;
        p = (~^{a, cmd}) ^ bad;
        start_frame();
        for (int i = 3; i >= 0; i--) send_bit(a[i]);
        for (int i = 7; i >= 0; i--) send_bit(cmd[i]);
        send_bit(p);
    endtask

    task automatic wr0(input logic [3:0] a, input logic [6:0] v, input bit bad);
        busy = 1'b1;
        header(a, {1'b1, v}, bad);
        send_bit(1'b0);
        tick(4);
        if (!bad && hits(a)) m_write(5'h00, {1'b0, v});
        busy = 1'b0;
        tick(4);
    endtask

    task automatic wr(input logic [3:0] a, input logic [4:0] ra, input logic [7:0] d,
                      input bit badc, input bit badd);
        busy = 1'b1;
        header(a, {3'b010, ra}, badc);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        send_bit((~^d) ^ badd);
        send_bit(1'b0);
        tick(4);
        if (!badc && !badd && hits(a)) m_write(ra, d);
        busy = 1'b0;
        tick(4);
    endtask

    task automatic rd(input logic [3:0] a, input logic [4:0] ra, input string req,
                      input bit drive);
        logic [7:0] e;
        logic [8:0] w;
        busy = 1'b1;
        e = m_read(ra);
        w = {e, ~^e};
        header(a, {3'b011, ra}, 1'b0);
        send_bit(1'b0);                         // bus park, master releases
        for (int i = 8; i >= 0; i--) begin
            sclk = 1'b1; sdi = 1'b0; tick(4);
            if (drive) begin
                chk({req, " R9 enable"}, {31'd0, sdo_oe}, 32'd1);
                chk({req, " R6 bit"}, {31'd0, sdo}, {31'd0, w[i]});
            end else begin
                chk({req, " R8 no drive"}, {31'd0, sdo_oe}, 32'd0);
            end
            sclk = 1'b0; tick(4);
        end
        sclk = 1'b1; tick(4);
        chk({req, " R9 released at park"}, {31'd0, sdo_oe}, 32'd0);
        sclk = 1'b0; tick(4);
        busy = 1'b0;
        tick(4);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        m_reset();
        tick(5);
        chk("R1 reset defaults", {8'd0, vset, msel, g0, g1, pmode, trig, sdo_oe},
            {8'd0, 7'd0, 2'b01, 1'b0, 1'b0, 2'b01, 6'd0, 1'b0});
        vio = 1'b1; tick(3);
        busy = 1'b0; tick(4);

        // R4 register writes and field mapping
        wr(4'h5, 5'h00, 8'h3A, 0, 0);
        chk("R4 vset", {25'd0, vset}, 32'h3A);
        wr(4'h5, 5'h01, 8'hC0, 0, 0);
        chk("R4 mode", {30'd0, msel}, 32'h3);
        wr(4'h5, 5'h02, 8'h80, 0, 0);
        chk("R4 gpo0", {30'd0, g0, g1}, 32'h2);
        wr(4'h5, 5'h02, 8'h40, 0, 0);
        chk("R4 gpo1", {30'd0, g0, g1}, 32'h1);
        wr(4'h5, 5'h1C, 8'h96, 0, 0);
        chk("R4 power mode and trigger", {24'd0, pmode, trig}, 32'h96);

        // R3 compact register-zero write
        wr0(4'h5, 7'h75, 0);
        chk("R3 vset", {25'd0, vset}, 32'h75);
        chk("R3 others kept", {22'd0, msel, g0, g1, pmode, trig}, {22'd0, 2'b11, 1'b0, 1'b1, 8'h96});

        // R2 address decode
        wr0(4'h0, 7'h20, 0);
        chk("R2 broadcast write", {25'd0, vset}, 32'h20);
        wr(4'h3, 5'h00, 8'h11, 0, 0);
        chk("R2 foreign address ignored", {25'd0, vset}, 32'h20);
        wr0(4'hA, 7'h01, 0);
        chk("R2 foreign compact write ignored", {25'd0, vset}, 32'h20);

        // R5 parity
        wr(4'h5, 5'h00, 8'h55, 1, 0);
        chk("R5 bad command parity", {25'd0, vset}, 32'h20);
        wr(4'h5, 5'h00, 8'h55, 0, 1);
        chk("R5 bad data parity", {25'd0, vset}, 32'h20);
        wr0(4'h5, 7'h10, 1);
        chk("R5 bad compact parity", {25'd0, vset}, 32'h20);

        // R7 reserved and read-only addresses
        wr(4'h5, 5'h05, 8'hFF, 0, 0);
        wr(4'h5, 5'h1D, 8'h00, 0, 0);
        wr(4'h5, 5'h1F, 8'hFF, 0, 0);
        rd(4'h5, 5'h05, "R7 reserved reads zero", 1);
        rd(4'h5, 5'h1B, "R7 reserved top reads zero", 1);

        // R6 reads
        rd(4'h5, 5'h1D, "R6 product id", 1);
        rd(4'h5, 5'h1E, "R6 manufacturer low", 1);
        rd(4'h5, 5'h1F, "R6 id register", 1);
        rd(4'h5, 5'h00, "R6 vset", 1);
        rd(4'h5, 5'h01, "R6 mode with reserved zeros", 1);
        rd(4'h5, 5'h02, "R6 gpo", 1);
        rd(4'h5, 5'h1C, "R6 power mode", 1);

        // R8 broadcast read gets no answer
        rd(4'h0, 5'h00, "R8 broadcast read", 0);

        // R10 reset in the middle of a read
        busy = 1'b1;
        header(4'h5, {3'b011, 5'h1D}, 1'b0);
        send_bit(1'b0);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
        end
        sclk = 1'b1; tick(2);
        chk("R10 enable before drop", {31'd0, sdo_oe}, 32'd1);
        vio = 1'b0; tick(2);
        chk("R10 enable dropped", {31'd0, sdo_oe}, 32'd0);
        sclk = 1'b0; sdi = 1'b0; tick(4);
        chk("R10 defaults restored", {8'd0, vset, msel, g0, g1, pmode, trig},
            {8'd0, 7'd0, 2'b01, 1'b0, 1'b0, 2'b01, 6'd0});
        vio = 1'b1; m_reset(); tick(2);
        busy = 1'b0; tick(4);

        // R1 defaults also read back after recovery, then a fresh write works
        rd(4'h5, 5'h01, "R1 mode default readback", 1);
        wr(4'h5, 5'h1C, 8'h41, 0, 0);
        chk("R4 write after recovery", {24'd0, pmode, trig}, 32'h41);

        tick(10);
        finish_run();
    end

endmodule